// File: doc/BRIEF.md
# ADC Register Bank

This block is the software-facing register set of an analog-to-digital converter. It sits between a simple synchronous processor bus and a conversion engine. The bus side has an address, a write strobe, a read strobe, write data and registered read data. The engine side is reduced to a busy level, a one-cycle done strobe and a 12-bit result bus.

The bank holds several registers:

- a 5-bit selector for the negative input channel;
- a status word whose only live bit is a ready flag;
- the captured conversion result;
- 10-bit gain and offset calibration words;
- a reset location. Writing any value to the reset location returns every register to its default.

The ready flag drives a level interrupt. It drops when software reads the result. The engine's busy level is forwarded to an external pin when an enable from the converter's control logic allows it.

Top module: `adc_regbank`

## Requirements
- R1: After reset the registers read as follows: channel select 0x01, status 0, result 0, gain 0x200 and offset 0x200. `adcIrq` is low.
- R2: Channel select sits at offset 0x08. A write stores `busWdata[4:0]`. A read returns the stored 5 bits, and bits 31:5 read as zero. Read data appears on `busRdata` in the cycle after the `busRd` strobe.
- R3: Gain sits at offset 0x30 and offset calibration at offset 0x34. Each stores `busWdata[9:0]`. Each reads back with bits 31:10 zero.
- R4: A `engDone` pulse captures `engResult` into the result register at offset 0x10. It also sets the ready flag, which is bit 0 of the status register at offset 0x0C. `adcIrq` is high from the next cycle.
- R5: A read of offset 0x10 clears the ready flag and `adcIrq` in the following cycle.
- R6: A result read and an `engDone` in the same cycle interact as follows. The ready flag stays set. The read returns the result held before that cycle. The new result is kept for the next read.
- R7: A write of any value to offset 0x14 restores all registers to their defaults and clears the ready flag. This happens even if `engDone` arrives in the same cycle.
- R8: Writes to the status and result offsets are ignored. Reads of unmapped offsets return zero.
- R9: `busyPin` is high exactly when `engBusy` and `busyPinEn` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte offset of the accessed register |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| engBusy | input | 1 | Engine converting |
| engDone | input | 1 | One-cycle end-of-conversion strobe |
| engResult | input | 12 | Conversion result, valid with engDone |
| busyPinEn | input | 1 | Allows busy onto the external pin |
| busyPin | output | 1 | External busy indication |
| adcIrq | output | 1 | Level interrupt, equal to the ready flag |

## Verification
Two events can land in the same clock: an engine completion and a software read of the result. A reset-location write can also coincide with a completion. The bench drives `engDone` in the very cycle that the read or reset write is on the bus. It then judges two things: the read data, which must hold the earlier result, and the interrupt level on the next cycle, which must stay high after the read and go low after the reset. A further read confirms which result value survived.

// File: rtl/adc_regbank_pkg.sv
package adc_regbank_pkg;

  localparam int OFF_CHAN = 'h08;
  localparam int OFF_STAT = 'h0C;
  localparam int OFF_RES  = 'h10;
  localparam int OFF_RST  = 'h14;
  localparam int OFF_GAIN = 'h30;
  localparam int OFF_OFFS = 'h34;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CHAN, SEL_STAT, SEL_RES, SEL_GAIN, SEL_OFFS
  } rdSel_t;

  typedef struct packed {
    logic   wrChan;
    logic   wrGain;
    logic   wrOffs;
    logic   softRst;
    logic   rdResult;
    logic   rdEn;
    rdSel_t rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/adc_regbank_ctrl.sv
module adc_regbank_ctrl
  import adc_regbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output ctrlStrobe_t       strobe
);

  logic hitChan, hitStat, hitRes, hitRst, hitGain, hitOffs;

  assign hitChan = (busAddr == ADDR_W'(OFF_CHAN));
  assign hitStat = (busAddr == ADDR_W'(OFF_STAT));
  assign hitRes  = (busAddr == ADDR_W'(OFF_RES));
  assign hitRst  = (busAddr == ADDR_W'(OFF_RST));
  assign hitGain = (busAddr == ADDR_W'(OFF_GAIN));
  assign hitOffs = (busAddr == ADDR_W'(OFF_OFFS));

  always_comb begin
    strobe          = '0;
    strobe.wrChan   = busWr && hitChan;
    strobe.wrGain   = busWr && hitGain;
    strobe.wrOffs   = busWr && hitOffs;
    strobe.softRst  = busWr && hitRst;
    strobe.rdResult = busRd && hitRes;
    strobe.rdEn     = busRd;
    if      (hitChan) strobe.rdSel = SEL_CHAN;
    else if (hitStat) strobe.rdSel = SEL_STAT;
    else if (hitRes)  strobe.rdSel = SEL_RES;
    else if (hitGain) strobe.rdSel = SEL_GAIN;
    else if (hitOffs) strobe.rdSel = SEL_OFFS;
    else              strobe.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/adc_regbank_dp.sv
module adc_regbank_dp
  import adc_regbank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RES_W    = 12,
  parameter int CHAN_W   = 5,
  parameter int CAL_W    = 10,
  parameter int CHAN_RST = 1,
  parameter int CAL_RST  = 'h200
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic              engDone,
  input  logic [RES_W-1:0]  engResult,
  output logic [DATA_W-1:0] rdata,
  output logic              readyFlag
);

  localparam logic [CHAN_W-1:0] CHAN_DEF = CHAN_W'(CHAN_RST);
  localparam logic [CAL_W-1:0]  CAL_DEF  = CAL_W'(CAL_RST);

  logic [CHAN_W-1:0] chanSel;
  logic [CAL_W-1:0]  gainCal, offsCal;
  logic [RES_W-1:0]  resultReg;
  logic              ready;
  logic [DATA_W-1:0] rdMux;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.softRst) begin
      chanSel   <= CHAN_DEF;
      gainCal   <= CAL_DEF;
      offsCal   <= CAL_DEF;
      resultReg <= '0;
      ready     <= 1'b0;
    end else begin
      if (strobe.wrChan) chanSel <= wdata[CHAN_W-1:0];
      if (strobe.wrGain) gainCal <= wdata[CAL_W-1:0];
      if (strobe.wrOffs) offsCal <= wdata[CAL_W-1:0];
      if (engDone) resultReg <= engResult;
      if (engDone)              ready <= 1'b1;
      else if (strobe.rdResult) ready <= 1'b0;
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_CHAN: rdMux = DATA_W'(chanSel);
      SEL_STAT: rdMux = DATA_W'(ready);
      SEL_RES:  rdMux = DATA_W'(resultReg);
      SEL_GAIN: rdMux = DATA_W'(gainCal);
      SEL_OFFS: rdMux = DATA_W'(offsCal);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdata <= '0;
    else if (strobe.rdEn) rdata <= rdMux;
  end

  assign readyFlag = ready;

endmodule

// File: rtl/adc_regbank.sv
module adc_regbank
  import adc_regbank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              engBusy,
  input  logic              engDone,
  input  logic [RES_W-1:0]  engResult,
  input  logic              busyPinEn,
  output logic              busyPin,
  output logic              adcIrq
);

  ctrlStrobe_t strobe;

  adc_regbank_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .busAddr(busAddr),
    .busWr  (busWr),
    .busRd  (busRd),
    .strobe (strobe)
  );

  adc_regbank_dp #(.DATA_W(DATA_W), .RES_W(RES_W)) dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wdata    (busWdata),
    .engDone  (engDone),
    .engResult(engResult),
    .rdata    (busRdata),
    .readyFlag(adcIrq)
  );

  assign busyPin = engBusy && busyPinEn;

endmodule

// File: rtl/adc_regbank_checker.sv
module adc_regbank_checker
  import adc_regbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic              engBusy,
  input logic              engDone,
  input logic              busyPinEn,
  input logic              busyPin,
  input logic              adcIrq
);

  logic wrRst, rdRes;
  assign wrRst = busWr && (busAddr == ADDR_W'(OFF_RST));
  assign rdRes = busRd && (busAddr == ADDR_W'(OFF_RES));

  assert_done_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    engDone && !wrRst |=> adcIrq);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdRes && !engDone && !wrRst |=> !adcIrq);

  assert_done_beats_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdRes && engDone && !wrRst |=> adcIrq);

  assert_softrst_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrRst |=> !adcIrq);

  assert_no_spurious_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    !adcIrq && !engDone |=> !adcIrq);

  assert_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    adcIrq && !rdRes && !wrRst |=> adcIrq);

  assert_busy_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busyPinEn |-> !busyPin);

  assert_busy_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !engBusy |-> !busyPin);

endmodule

bind adc_regbank adc_regbank_checker #(.ADDR_W(ADDR_W)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWr    (busWr),
  .busRd    (busRd),
  .engBusy  (engBusy),
  .engDone  (engDone),
  .busyPinEn(busyPinEn),
  .busyPin  (busyPin),
  .adcIrq   (adcIrq)
);

// File: tb/adc_regbank_test.sv
module adc_regbank_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        engBusy = 1'b0, engDone = 1'b0, busyPinEn = 1'b0;
  logic [11:0] engResult = '0;
  logic        busyPin, adcIrq;

  int checks = 0, errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  adc_regbank uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .engBusy(engBusy),
    .engDone(engDone), .engResult(engResult), .busyPinEn(busyPinEn),
    .busyPin(busyPin), .adcIrq(adcIrq)
  );

  // monitor: one read result per strobed cycle, compared against the queue
  always @(posedge clk) rdSeen <= busRd;
  always @(negedge clk) begin
    if (rdSeen) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (busRdata !== e) begin
        errors++;
        $display("FAIL %s read actual %h expected %h", t, busRdata, e);
      end
    end
  end

  task automatic checkBit(input string t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", t, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [31:0] e, input string t);
    busAddr = a; busRd = 1'b1;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic engFinish(input logic [11:0] r);
    engResult = r; engDone = 1'b1;
    @(negedge clk);
    engDone = 1'b0;
  endtask

  task automatic checkDefaults(input string t);
    busRead(8'h08, 32'h1, t);
    busRead(8'h0C, 32'h0, t);
    busRead(8'h10, 32'h0, t);
    busRead(8'h30, 32'h200, t);
    busRead(8'h34, 32'h200, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkBit("R1 irq", adcIrq, 1'b0);
    checkDefaults("R1");

    busWrite(8'h08, 32'hFFFF_FFF0);
    busRead(8'h08, 32'h10, "R2 chan");
    busWrite(8'h08, 32'h0000_0007);
    busRead(8'h08, 32'h7, "R2 chan");
    busWrite(8'h30, 32'hFFFF_FFFF);
    busRead(8'h30, 32'h3FF, "R3 gain");
    busWrite(8'h34, 32'h0000_0155);
    busRead(8'h34, 32'h155, "R3 offset");

    busWrite(8'h0C, 32'h1);
    busWrite(8'h10, 32'hABC);
    checkBit("R8 irq after status write", adcIrq, 1'b0);
    busRead(8'h0C, 32'h0, "R8 status");
    busRead(8'h10, 32'h0, "R8 result");
    busRead(8'h20, 32'h0, "R8 unmapped");

    engFinish(12'h5A5);
    checkBit("R4 irq", adcIrq, 1'b1);
    busRead(8'h0C, 32'h1, "R4 status");
    busRead(8'h10, 32'h5A5, "R4 result");
    checkBit("R5 irq cleared", adcIrq, 1'b0);
    busRead(8'h0C, 32'h0, "R5 status");

    engFinish(12'h123);
    // R6: result read and completion in one cycle
    busAddr = 8'h10; busRd = 1'b1; engResult = 12'h456; engDone = 1'b1;
    expQ.push_back(32'h123); tagQ.push_back("R6 old result");
    @(negedge clk);
    busRd = 1'b0; engDone = 1'b0;
    checkBit("R6 irq kept", adcIrq, 1'b1);
    busRead(8'h10, 32'h456, "R6 new result");
    checkBit("R6 irq cleared later", adcIrq, 1'b0);

    engBusy = 1'b1; busyPinEn = 1'b0; #1;
    checkBit("R9 gated", busyPin, 1'b0);
    busyPinEn = 1'b1; #1;
    checkBit("R9 on", busyPin, 1'b1);
    engBusy = 1'b0; #1;
    checkBit("R9 idle", busyPin, 1'b0);
    busyPinEn = 1'b0;
    @(negedge clk);

    engFinish(12'h777);
    busWrite(8'h14, 32'hDEAD_BEEF);
    checkBit("R7 irq", adcIrq, 1'b0);
    checkDefaults("R7");

    busWrite(8'h30, 32'h3);
    // R7: reset write and completion in one cycle
    busAddr = 8'h14; busWdata = 32'h0; busWr = 1'b1; engResult = 12'hFFF; engDone = 1'b1;
    @(negedge clk);
    busWr = 1'b0; engDone = 1'b0;
    checkBit("R7 irq vs done", adcIrq, 1'b0);
    checkDefaults("R7 vs done");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule